// File: doc/BRIEF.md
# Display Write-Address Counter

This block holds the write pointers that a dot-matrix display controller uses for its three writable spaces: a bit-mapped dot plane addressed by byte column and row, a character plane addressed by character column and character row, and a user glyph memory addressed by glyph code and glyph line. The host loads any coordinate through a load strobe with an 8-bit value. After each data write tagged with a space, the pointer of that space advances according to a 2-bit step mode.

Every load is checked against the legal range of its coordinate. A value above the range is clamped to the largest legal value, and a one-cycle error pulse is raised. The block also presents the write data already trimmed for the addressed memory. The last byte column of the dot plane carries only seven dots, and glyph rows are five dots wide. A flag marks the unused eighth glyph line, where the host sends a filler write.

Top module: `disp_addr_ctr`

## Requirements
- R1: While rst_n is low at a rising edge, every pointer becomes 0 and range_err becomes 0.
- R2: A load strobe (ld_fx, ld_fy, ld_cx, ld_cy, ld_cg) with an in-range ld_data puts that value in the matching pointer after the edge. The legal maxima are dot column 14, dot row 72, char column 21, char row 7 and glyph address 127.
- R3: A load whose ld_data exceeds the maximum stores the maximum. range_err is 1 in the cycle after such a load and 0 after any cycle without one.
- R4: With step mode 00, a dot write advances the column. From column 14 the column goes to 0 and the row advances, and the row goes from 72 to 0.
- R5: With step mode 01, a dot write advances the row. From row 72 the row goes to 0 and the column advances, and the column goes from 14 to 0.
- R6: With step mode 00, a character write advances the column. From any column of 19 or more, the column goes to 0 and the row advances (7 goes to 0).
- R7: With step mode 01, a character write advances the row. From row 7 the row goes to 0 and the column advances, with the same return to 0 from column 19 or more.
- R8: In step modes 00 and 01 alike, a glyph write adds 1 to the 7-bit glyph address {code[3:0], line[2:0]}. Line 6 goes to line 7, line 7 goes to line 0 of the next code, and 127 goes to 0.
- R9: With step mode 10 or 11, a data write leaves every pointer unchanged.
- R10: wr_space selects the space a write steps (00 dot, 01 character, 10 glyph, 11 none). No other pointer moves, and with wr_en low nothing moves.
- R11: A load of either coordinate of a space in the same cycle as a write to that space loads the value and cancels the step for that space.
- R12: fd_bytemask is 8'hFE at dot column 14 and 8'hFF elsewhere, and fd_wdata is wr_data ANDed with it.
- R13: cg_wdata is wr_data with bits 7..5 cleared. cg_dummy is 1 exactly when glyph line bits [2:0] equal 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_fx | input | 1 | Load dot column |
| ld_fy | input | 1 | Load dot row |
| ld_cx | input | 1 | Load character column |
| ld_cy | input | 1 | Load character row |
| ld_cg | input | 1 | Load glyph address |
| ld_data | input | 8 | Value for loads |
| wr_en | input | 1 | Data write happened |
| wr_space | input | 2 | Space of the data write |
| inc_mode | input | 2 | Step mode: 00 column, 01 row, 1x hold |
| wr_data | input | 8 | Host write byte |
| fd_x | output | 4 | Dot byte column |
| fd_y | output | 7 | Dot row |
| ch_x | output | 5 | Character column |
| ch_y | output | 3 | Character row |
| cg_addr | output | 7 | Glyph address {code, line} |
| cg_dummy | output | 1 | Glyph line is the unused eighth line |
| fd_bytemask | output | 8 | Valid dots of the current dot byte |
| fd_wdata | output | 8 | Dot write byte, trimmed |
| cg_wdata | output | 8 | Glyph write byte, trimmed |
| range_err | output | 1 | Previous cycle had a clamped load |

## Verification
The assertions assume that every strobe and field is a defined 0 or 1 from the first edge after reset. They also assume that wr_space 11 is a legal idle code, not a fault. The ordering assertions assume that step mode holds its value during the cycle it is sampled. The stimulus changes inputs only on falling edges and keeps all controls at known values throughout. It uses random loads and writes over all spaces and modes, and these may overlap, because the block defines how a load and a write in the same cycle combine.

// File: rtl/disp_addr_pkg.sv
// Shared codes for the display write-address counter.
// Assumes wr_space and inc_mode are 2-bit fields as defined below.
package disp_addr_pkg;
    // Space selected by a data write
    localparam logic [1:0] SPC_DOT  = 2'b00;
    localparam logic [1:0] SPC_CHAR = 2'b01;
    localparam logic [1:0] SPC_GLYF = 2'b10;
    localparam logic [1:0] SPC_NONE = 2'b11;

    // Step modes; bit 1 set means hold
    localparam logic [1:0] STEP_COL = 2'b00;
    localparam logic [1:0] STEP_ROW = 2'b01;
endpackage

// File: rtl/disp_xy_ptr.sv
// Two-coordinate write pointer with clamped loads and carry between axes.
// Column steps wrap at X_WRAP (any column >= X_WRAP returns to 0);
// row steps wrap at Y_MAX. A load of either axis cancels a step.
module disp_xy_ptr #(
    parameter int DW     = 8,
    parameter int X_MAX  = 14,
    parameter int X_WRAP = 14,
    parameter int Y_MAX  = 72,
    parameter int XW     = $clog2(X_MAX + 1),
    parameter int YW     = $clog2(Y_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_x,
    input  logic          ld_y,
    input  logic [DW-1:0] ld_val,
    input  logic          step,
    input  logic          step_row,
    output logic [XW-1:0] x_q,
    output logic [YW-1:0] y_q,
    output logic          sat
);
    logic          x_big, y_big;
    logic [XW-1:0] x_ld, x_nx, x_adv;
    logic [YW-1:0] y_ld, y_nx, y_adv;
    logic          x_end, y_end;

    // Clamp a load value to each axis range
    always_comb begin
        x_big = ld_val > DW'(X_MAX);
        y_big = ld_val > DW'(Y_MAX);
        x_ld  = x_big ? XW'(X_MAX) : ld_val[XW-1:0];
        y_ld  = y_big ? YW'(Y_MAX) : ld_val[YW-1:0];
        sat   = (ld_x & x_big) | (ld_y & y_big);
    end

    // Single-axis advance values with wrap to zero
    always_comb begin
        x_end = x_q >= XW'(X_WRAP);
        y_end = y_q >= YW'(Y_MAX);
        x_adv = x_end ? '0 : x_q + 1'b1;
        y_adv = y_end ? '0 : y_q + 1'b1;
    end

    // Next pointer: load first, else step the selected axis with carry
    always_comb begin
        x_nx = x_q;
        y_nx = y_q;
        if (ld_x || ld_y) begin
            if (ld_x) x_nx = x_ld;
            if (ld_y) y_nx = y_ld;
        end else if (step) begin
            if (!step_row) begin
                x_nx = x_adv;
                if (x_end) y_nx = y_adv;
            end else begin
                y_nx = y_adv;
                if (y_end) x_nx = x_adv;
            end
        end
    end

    // Pointer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            x_q <= x_nx;
            y_q <= y_nx;
        end
    end
endmodule

// File: rtl/disp_glyph_ptr.sv
// Glyph memory pointer {code, line}: one linear counter that always
// steps through lines first, so the unused last line is visited too.
// Loads above the top address clamp to it.
module disp_glyph_ptr #(
    parameter int DW     = 8,
    parameter int CODE_W = 4,
    parameter int LINE_W = 3,
    parameter int AW     = CODE_W + LINE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [DW-1:0] ld_val,
    input  logic          step,
    output logic [AW-1:0] addr_q,
    output logic          sat
);
    localparam int A_MAX = (1 << AW) - 1;

    logic          big;
    logic [AW-1:0] a_ld;

    // Clamp the load value
    always_comb begin
        big  = ld_val > DW'(A_MAX);
        a_ld = big ? AW'(A_MAX) : ld_val[AW-1:0];
        sat  = ld & big;
    end

    // Address register: load wins, else line-order increment
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else if (ld) addr_q <= a_ld;
        else if (step) addr_q <= addr_q + 1'b1;
    end
endmodule

// File: rtl/disp_addr_ctr.sv
// Write-address counter for the dot plane, character plane and glyph
// memory of a dot-matrix display controller. Decodes write steps per
// space and mode, clamps loads, and trims write bytes per memory.
// Assumes one write tag per cycle; loads may coincide with writes.
module disp_addr_ctr
    import disp_addr_pkg::*;
#(
    parameter int DW       = 8,
    parameter int FD_DOTS  = 119,
    parameter int FD_ROWS  = 73,
    parameter int CH_COLS  = 22,
    parameter int CH_VIS   = 20,
    parameter int CH_ROWS  = 8,
    parameter int CG_CODES = 16,
    parameter int CG_LINES = 8,
    parameter int CG_BITS  = 5,
    parameter int FD_XMAX  = (FD_DOTS - 1) / DW,
    parameter int FD_XW    = $clog2(FD_XMAX + 1),
    parameter int FD_YW    = $clog2(FD_ROWS),
    parameter int CH_XW    = $clog2(CH_COLS),
    parameter int CH_YW    = $clog2(CH_ROWS),
    parameter int CG_AW    = $clog2(CG_CODES) + $clog2(CG_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_fx,
    input  logic             ld_fy,
    input  logic             ld_cx,
    input  logic             ld_cy,
    input  logic             ld_cg,
    input  logic [DW-1:0]    ld_data,
    input  logic             wr_en,
    input  logic [1:0]       wr_space,
    input  logic [1:0]       inc_mode,
    input  logic [DW-1:0]    wr_data,
    output logic [FD_XW-1:0] fd_x,
    output logic [FD_YW-1:0] fd_y,
    output logic [CH_XW-1:0] ch_x,
    output logic [CH_YW-1:0] ch_y,
    output logic [CG_AW-1:0] cg_addr,
    output logic             cg_dummy,
    output logic [DW-1:0]    fd_bytemask,
    output logic [DW-1:0]    fd_wdata,
    output logic [DW-1:0]    cg_wdata,
    output logic             range_err
);
    localparam int LAST_BITS = FD_DOTS - DW * FD_XMAX;
    localparam int LINE_W    = $clog2(CG_LINES);
    localparam logic [DW-1:0] LAST_MASK = {DW{1'b1}} << (DW - LAST_BITS);
    localparam logic [DW-1:0] CG_MASK   = {DW{1'b1}} >> (DW - CG_BITS);

    logic step_ok, fd_step, ch_step, cg_step;
    logic fd_sat, ch_sat, cg_sat;

    // Decode which space steps this cycle
    always_comb begin
        step_ok = wr_en && !inc_mode[1];
        fd_step = step_ok && (wr_space == SPC_DOT);
        ch_step = step_ok && (wr_space == SPC_CHAR);
        cg_step = step_ok && (wr_space == SPC_GLYF);
    end

    disp_xy_ptr #(
        .DW(DW), .X_MAX(FD_XMAX), .X_WRAP(FD_XMAX), .Y_MAX(FD_ROWS - 1),
        .XW(FD_XW), .YW(FD_YW)
    ) u_dot (
        .clk(clk), .rst_n(rst_n), .ld_x(ld_fx), .ld_y(ld_fy), .ld_val(ld_data),
        .step(fd_step), .step_row(inc_mode[0]), .x_q(fd_x), .y_q(fd_y),
        .sat(fd_sat)
    );

    disp_xy_ptr #(
        .DW(DW), .X_MAX(CH_COLS - 1), .X_WRAP(CH_VIS - 1), .Y_MAX(CH_ROWS - 1),
        .XW(CH_XW), .YW(CH_YW)
    ) u_chr (
        .clk(clk), .rst_n(rst_n), .ld_x(ld_cx), .ld_y(ld_cy), .ld_val(ld_data),
        .step(ch_step), .step_row(inc_mode[0]), .x_q(ch_x), .y_q(ch_y),
        .sat(ch_sat)
    );

    disp_glyph_ptr #(
        .DW(DW), .CODE_W($clog2(CG_CODES)), .LINE_W(LINE_W), .AW(CG_AW)
    ) u_gly (
        .clk(clk), .rst_n(rst_n), .ld(ld_cg), .ld_val(ld_data),
        .step(cg_step), .addr_q(cg_addr), .sat(cg_sat)
    );

    // One-cycle pulse after a clamped load
    always_ff @(posedge clk) begin
        if (!rst_n) range_err <= 1'b0;
        else        range_err <= fd_sat | ch_sat | cg_sat;
    end

    // Trim write bytes to the dots each memory holds
    always_comb begin
        fd_bytemask = (fd_x == FD_XW'(FD_XMAX)) ? LAST_MASK : {DW{1'b1}};
        fd_wdata    = wr_data & fd_bytemask;
        cg_wdata    = wr_data & CG_MASK;
        cg_dummy    = &cg_addr[LINE_W-1:0];
    end
endmodule

// File: rtl/disp_addr_ctr_chk.sv
// Property checker for disp_addr_ctr, attached by bind below.
// Assumes default-sized ports; observes only top-level ports.
module disp_addr_ctr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ld_fx,
    input logic       ld_fy,
    input logic       ld_cx,
    input logic       ld_cy,
    input logic       ld_cg,
    input logic [7:0] ld_data,
    input logic       wr_en,
    input logic [1:0] wr_space,
    input logic [1:0] inc_mode,
    input logic [3:0] fd_x,
    input logic [6:0] fd_y,
    input logic [4:0] ch_x,
    input logic [2:0] ch_y,
    input logic [6:0] cg_addr,
    input logic       range_err
);
    logic any_ld;
    assign any_ld = ld_fx | ld_fy | ld_cx | ld_cy | ld_cg;

    AST_FD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_fx && ld_data <= 8'd14) |=> fd_x == $past(ld_data[3:0])); // R2
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> $past(any_ld)); // R3
    AST_FD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fd_x <= 4'd14 && fd_y <= 7'd72); // R4
    AST_CH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ch_x <= 5'd21); // R6
    AST_CG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_space == 2'b10 && !inc_mode[1] && !ld_cg)
        |=> cg_addr == $past(cg_addr) + 7'd1); // R8
    AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && inc_mode[1] && !any_ld)
        |=> $stable(fd_x) && $stable(fd_y) && $stable(ch_x) && $stable(ch_y) && $stable(cg_addr)); // R9
    AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !any_ld)
        |=> $stable(fd_x) && $stable(fd_y) && $stable(ch_x) && $stable(ch_y) && $stable(cg_addr)); // R10
endmodule

bind disp_addr_ctr disp_addr_ctr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ld_fx(ld_fx), .ld_fy(ld_fy), .ld_cx(ld_cx),
    .ld_cy(ld_cy), .ld_cg(ld_cg), .ld_data(ld_data), .wr_en(wr_en),
    .wr_space(wr_space), .inc_mode(inc_mode), .fd_x(fd_x), .fd_y(fd_y),
    .ch_x(ch_x), .ch_y(ch_y), .cg_addr(cg_addr), .range_err(range_err)
);

// File: tb/disp_addr_ctr_bench.sv
// Bench: behavioural reference model, compared after every clock.
module disp_addr_ctr_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_fx = 0, ld_fy = 0, ld_cx = 0, ld_cy = 0, ld_cg = 0;
    logic [7:0] ld_data = 0;
    logic       wr_en = 0;
    logic [1:0] wr_space = 2'b11;
    logic [1:0] inc_mode = 0;
    logic [7:0] wr_data = 0;
    logic [3:0] fd_x;
    logic [6:0] fd_y;
    logic [4:0] ch_x;
    logic [2:0] ch_y;
    logic [6:0] cg_addr;
    logic       cg_dummy, range_err;
    logic [7:0] fd_bytemask, fd_wdata, cg_wdata;

    int checks = 0, fails = 0;
    bit done = 0;
    int m_fx, m_fy, m_cx, m_cy, m_cg, m_err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    disp_addr_ctr u_disp_addr_ctr (
        .clk(clk), .rst_n(rst_n), .ld_fx(ld_fx), .ld_fy(ld_fy), .ld_cx(ld_cx),
        .ld_cy(ld_cy), .ld_cg(ld_cg), .ld_data(ld_data), .wr_en(wr_en),
        .wr_space(wr_space), .inc_mode(inc_mode), .wr_data(wr_data),
        .fd_x(fd_x), .fd_y(fd_y), .ch_x(ch_x), .ch_y(ch_y), .cg_addr(cg_addr),
        .cg_dummy(cg_dummy), .fd_bytemask(fd_bytemask), .fd_wdata(fd_wdata),
        .cg_wdata(cg_wdata), .range_err(range_err)
    );

    function automatic int clampv(int v, int mx, ref int e);
        if (v > mx) begin e = 1; return mx; end
        return v;
    endfunction

    // Reference model: updated once per rising edge from the driven inputs
    task automatic model_step();
        int e = 0;
        bit fl, cl, st;
        if (!rst_n) begin
            m_fx = 0; m_fy = 0; m_cx = 0; m_cy = 0; m_cg = 0; m_err = 0;
            return;
        end
        fl = ld_fx || ld_fy;
        cl = ld_cx || ld_cy;
        if (ld_fx) m_fx = clampv(ld_data, 14, e);
        if (ld_fy) m_fy = clampv(ld_data, 72, e);
        if (ld_cx) m_cx = clampv(ld_data, 21, e);
        if (ld_cy) m_cy = clampv(ld_data, 7, e);
        if (ld_cg) m_cg = clampv(ld_data, 127, e);
        m_err = e;
        st = wr_en && inc_mode < 2;
        if (st && wr_space == 2'b00 && !fl) begin
            if (inc_mode == 0) begin
                if (m_fx == 14) begin m_fx = 0; m_fy = (m_fy + 1) % 73; end
                else m_fx++;
            end else begin
                if (m_fy == 72) begin m_fy = 0; m_fx = (m_fx + 1) % 15; end
                else m_fy++;
            end
        end
        if (st && wr_space == 2'b01 && !cl) begin
            if (inc_mode == 0) begin
                if (m_cx >= 19) begin m_cx = 0; m_cy = (m_cy + 1) % 8; end
                else m_cx++;
            end else begin
                if (m_cy == 7) begin m_cy = 0; m_cx = (m_cx >= 19) ? 0 : m_cx + 1; end
                else m_cy++;
            end
        end
        if (st && wr_space == 2'b10 && !ld_cg) m_cg = (m_cg + 1) % 128;
    endtask

    task automatic compare(input string tag);
        int em;
        bit bad;
        em = (m_fx == 14) ? 8'hFE : 8'hFF;
        bad = (fd_x != m_fx) || (fd_y != m_fy) || (ch_x != m_cx) || (ch_y != m_cy) ||
              (cg_addr != m_cg) || (range_err != m_err) || (fd_bytemask != em) ||
              (fd_wdata != (wr_data & em)) || (cg_wdata != (wr_data & 8'h1F)) ||
              (cg_dummy != ((m_cg % 8) == 7));
        checks++;
        if (bad) begin
            fails++;
            $display("FAIL %s actual fx=%0d fy=%0d cx=%0d cy=%0d cg=%0d err=%0d mask=%h fdw=%h cgw=%h dum=%0d expected fx=%0d fy=%0d cx=%0d cy=%0d cg=%0d err=%0d mask=%h fdw=%h cgw=%h dum=%0d",
                     tag, fd_x, fd_y, ch_x, ch_y, cg_addr, range_err, fd_bytemask, fd_wdata,
                     cg_wdata, cg_dummy, m_fx, m_fy, m_cx, m_cy, m_cg, m_err, em,
                     wr_data & em[7:0], wr_data & 8'h1F, (m_cg % 8) == 7);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    // Drive one cycle: load select {fx,fy,cx,cy,cg}, value, write fields
    task automatic cyc(input logic [4:0] ls, input int val, input bit we,
                       input logic [1:0] sp, input logic [1:0] md,
                       input logic [7:0] wd, input string tag);
        {ld_fx, ld_fy, ld_cx, ld_cy, ld_cg} = ls;
        ld_data = 8'(val);
        wr_en = we; wr_space = sp; inc_mode = md; wr_data = wd;
        tick(tag);
        {ld_fx, ld_fy, ld_cx, ld_cy, ld_cg} = 5'b0;
        wr_en = 0;
    endtask

    task automatic wr(input logic [1:0] sp, input logic [1:0] md, input logic [7:0] wd,
                      input string tag);
        cyc(5'b0, 0, 1, sp, md, wd, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 0;
        cyc(5'b10000, 9, 1, 2'b00, 2'b00, 8'h00, "R1");
        cyc(5'b00001, 40, 0, 2'b11, 2'b00, 8'h00, "R1");
        rst_n = 1;
        cyc(5'b0, 0, 0, 2'b11, 2'b00, 8'h00, "R1");
        // R2 in-range loads
        cyc(5'b10000, 3, 0, 2'b11, 0, 0, "R2");
        cyc(5'b01000, 5, 0, 2'b11, 0, 0, "R2");
        cyc(5'b00100, 10, 0, 2'b11, 0, 0, "R2");
        cyc(5'b00010, 2, 0, 2'b11, 0, 0, "R2");
        cyc(5'b00001, 8'h12, 0, 2'b11, 0, 0, "R2");
        // R3 clamped loads and error pulse
        cyc(5'b10000, 200, 0, 2'b11, 0, 0, "R3");
        cyc(5'b0, 0, 0, 2'b11, 0, 0, "R3");
        cyc(5'b01000, 100, 0, 2'b11, 0, 0, "R3");
        cyc(5'b00100, 30, 0, 2'b11, 0, 0, "R3");
        cyc(5'b00010, 9, 0, 2'b11, 0, 0, "R3");
        cyc(5'b00001, 255, 0, 2'b11, 0, 0, "R3");
        cyc(5'b00001, 127, 0, 2'b11, 0, 0, "R3");
        // R4 dot column stepping with carry
        cyc(5'b10000, 12, 0, 2'b11, 0, 0, "R4");
        cyc(5'b01000, 3, 0, 2'b11, 0, 0, "R4");
        for (int i = 0; i < 4; i++) wr(2'b00, 2'b00, 8'hAB, "R4");
        cyc(5'b11000, 14, 0, 2'b11, 0, 0, "R4");
        cyc(5'b01000, 72, 0, 2'b11, 0, 8'hFF, "R12");
        wr(2'b00, 2'b00, 8'hFF, "R4");
        // R12 trimmed last byte column
        cyc(5'b10000, 14, 0, 2'b11, 0, 8'h37, "R12");
        cyc(5'b10000, 13, 0, 2'b11, 0, 8'h37, "R12");
        // R5 dot row stepping
        cyc(5'b10000, 2, 0, 2'b11, 0, 0, "R5");
        cyc(5'b01000, 70, 0, 2'b11, 0, 0, "R5");
        for (int i = 0; i < 4; i++) wr(2'b00, 2'b01, 8'h5A, "R5");
        cyc(5'b11000, 72, 0, 2'b11, 0, 0, "R5");
        cyc(5'b10000, 14, 0, 2'b11, 0, 0, "R5");
        wr(2'b00, 2'b01, 8'h01, "R5");
        // R6 character column stepping
        cyc(5'b00100, 17, 0, 2'b11, 0, 0, "R6");
        cyc(5'b00010, 1, 0, 2'b11, 0, 0, "R6");
        for (int i = 0; i < 4; i++) wr(2'b01, 2'b00, 8'h00, "R6");
        cyc(5'b00100, 21, 0, 2'b11, 0, 0, "R6");
        wr(2'b01, 2'b00, 8'h00, "R6");
        cyc(5'b00110, 7, 0, 2'b11, 0, 0, "R6");
        cyc(5'b00100, 19, 0, 2'b11, 0, 0, "R6");
        wr(2'b01, 2'b00, 8'h00, "R6");
        // R7 character row stepping
        cyc(5'b00100, 3, 0, 2'b11, 0, 0, "R7");
        cyc(5'b00010, 6, 0, 2'b11, 0, 0, "R7");
        for (int i = 0; i < 3; i++) wr(2'b01, 2'b01, 8'h00, "R7");
        cyc(5'b00110, 7, 0, 2'b11, 0, 0, "R7");
        cyc(5'b00100, 20, 0, 2'b11, 0, 0, "R7");
        wr(2'b01, 2'b01, 8'h00, "R7");
        // R8 and R13 glyph line order, dummy line, trimmed byte
        cyc(5'b00001, 8'h15, 0, 2'b11, 0, 0, "R8");
        for (int i = 0; i < 4; i++) wr(2'b10, 2'b00, 8'hFF, "R13");
        for (int i = 0; i < 3; i++) wr(2'b10, 2'b01, 8'hE6, "R8");
        cyc(5'b00001, 127, 0, 2'b11, 0, 0, "R8");
        wr(2'b10, 2'b00, 8'h80, "R8");
        // R9 hold modes on every space
        for (int s = 0; s < 3; s++) begin
            wr(2'(s), 2'b10, 8'h11, "R9");
            wr(2'(s), 2'b11, 8'h22, "R9");
        end
        // R10 idle space code
        wr(2'b11, 2'b00, 8'h33, "R10");
        wr(2'b11, 2'b01, 8'h33, "R10");
        // R11 load with concurrent write to the same space
        cyc(5'b10000, 6, 1, 2'b00, 2'b00, 0, "R11");
        cyc(5'b00010, 4, 1, 2'b01, 2'b01, 0, "R11");
        cyc(5'b00001, 8'h40, 1, 2'b10, 2'b00, 0, "R11");
        cyc(5'b01000, 9, 1, 2'b01, 2'b00, 0, "R11");
        // R10 random mix over all spaces and modes
        for (int i = 0; i < 600; i++) begin
            int r = $urandom % 10;
            logic [4:0] ls = (r < 5) ? 5'(1 << r) : 5'b0;
            cyc(ls, $urandom % 256, 1'($urandom % 2), 2'($urandom % 4),
                2'($urandom % 4), 8'($urandom % 256), "R10");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule